// File: doc/BRIEF.md
# Reset Cause Capture Register

This block merges four reset sources into one system reset and keeps an 8-bit record of the sources that have caused a reset. The sources are a power-on event, a watchdog overflow, a voltage-supervisor trip and an external active-low reset pin. Any active source pulls the system reset low at once. The reset is released two clock edges after the last source goes inactive.

The record is held in flag flops that the system reset never clears. A flag can change in only two ways: its own source sets it, or software writes it. Because of this, flags build up across several resets until software reads the byte and writes 00h to it. The external pin resets the system but leaves no trace in the record. Access uses a single address. The host drives a select strobe and a write enable, and reads the byte back on a combinational read port.

Top module: `rcc_unit`

## Requirements
- R1: The read byte carries the power-on flag at bit 0, the watchdog flag at bit 2 and the voltage-supervisor flag at bit 5. Bits 1, 3, 4, 6 and 7 always read as 0.
- R2: An active `por_i` sets bit 0 of the record.
- R3: An active `wdt_ovf_i` sets bit 2 of the record.
- R4: An active `vsup_trip_i` sets bit 5 of the record.
- R5: A low `rst_ni` asserts the system reset and leaves every flag unchanged.
- R6: No reset clears the record. Flags from successive resets accumulate: a watchdog reset followed by a voltage-supervisor reset reads 24h.
- R7: A write (`sel_i`=1, `we_i`=1) loads bits 0, 2 and 5 from `wdata_i`. Writing 00h clears the record. Write data on the reserved bit positions has no effect.
- R8: If a source sets a flag in the same cycle that software writes 0 to it, the flag ends at 1.
- R9: `sys_rst_no` goes low without waiting for a clock edge whenever any source is active. It returns high on the second rising clock edge after all sources are inactive.
- R10: `rdata_o` is 00h unless a read is in progress (`sel_i`=1, `we_i`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | External reset pin, active low |
| por_i | input | 1 | Power-on event, active high |
| wdt_ovf_i | input | 1 | Watchdog overflow request, active high |
| vsup_trip_i | input | 1 | Voltage-supervisor trip, active high |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| sys_rst_no | output | 1 | Combined system reset, active low |

## Verification
The case that is hardest to reach from the ports is a hardware set and a software clear hitting the same flag. While a source is active the system is held in reset, so this can only happen when the bus keeps writing during the reset. The bench raises the watchdog request and writes 00h in that same cycle, then checks that bit 2 still reads 1 once reset is released. A second hard case is accumulation. It needs two different resets in a row with no clear between them, so the bench follows a watchdog reset with a voltage-supervisor reset and expects both flags.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned REC_W   = 8;
  localparam int unsigned N_FLAGS = 3;
  // bit positions that software decodes
  localparam int unsigned POS_POR  = 0;
  localparam int unsigned POS_WDT  = 2;
  localparam int unsigned POS_VSUP = 5;

  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      0:       return POS_POR;
      1:       return POS_WDT;
      default: return POS_VSUP;
    endcase
  endfunction

  function automatic logic [REC_W-1:0] live_mask();
    logic [REC_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < N_FLAGS; i++) m[flag_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rcc_flag_cell.sv
module rcc_flag_cell #(
  parameter logic SEED = 1'b0
) (
  input  logic clk_i,
  input  logic set_i,
  input  logic wr_i,
  input  logic d_i,
  output logic q_o
);
  // power-up content is undefined; simulation starts from SEED
  logic q_q = SEED;

  always_ff @(posedge clk_i or posedge set_i) begin
    if (set_i)     q_q <= 1'b1;
    else if (wr_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/rcc_rst_sync.sv
module rcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rcc_unit.sv
module rcc_unit
  import rcc_pkg::*;
#(
  parameter int unsigned         SYNC_STAGES = 2,
  parameter logic [REC_W-1:0]    SEED        = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             wdt_ovf_i,
  input  logic             vsup_trip_i,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [REC_W-1:0] wdata_i,
  output logic [REC_W-1:0] rdata_o,
  output logic             sys_rst_no
);
  logic [N_FLAGS-1:0] src;
  logic [REC_W-1:0]   rec;
  logic               wr_en;
  logic               rd_en;
  logic               any_rst;

  assign src     = {vsup_trip_i, wdt_ovf_i, por_i};
  assign wr_en   = sel_i & we_i;
  assign rd_en   = sel_i & ~we_i;
  assign any_rst = (|src) | ~rst_ni;

  always_comb begin
    rec = '0;
    for (int unsigned i = 0; i < N_FLAGS; i++) rec[flag_pos(i)] = flag_q[i];
  end

  logic [N_FLAGS-1:0] flag_q;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    localparam int unsigned P = flag_pos(g);
    rcc_flag_cell #(.SEED(SEED[P])) u_cell (
      .clk_i (clk_i),
      .set_i (src[g]),
      .wr_i  (wr_en),
      .d_i   (wdata_i[P]),
      .q_o   (flag_q[g])
    );
  end

  rcc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .arst_i (any_rst),
    .rst_no (sys_rst_no)
  );

  assign rdata_o = rd_en ? (rec & live_mask()) : '0;
endmodule

// File: rtl/rcc_unit_chk.sv
module rcc_unit_chk
  import rcc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_i,
  input logic             wdt_ovf_i,
  input logic             vsup_trip_i,
  input logic             sel_i,
  input logic             we_i,
  input logic [REC_W-1:0] rdata_o,
  input logic             sys_rst_no,
  input logic [REC_W-1:0] rec
);
  logic any_src;
  logic wr_seen;
  assign any_src = por_i | wdt_ovf_i | vsup_trip_i | ~rst_ni;
  assign wr_seen = sel_i & we_i;

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (por_i)
    (rdata_o & ~live_mask()) == '0); // R1
  AST_WDT_SETS: assert property (@(posedge clk_i) disable iff (por_i)
    wdt_ovf_i |=> rec[POS_WDT]); // R3
  AST_VSUP_SETS: assert property (@(posedge clk_i) disable iff (por_i)
    vsup_trip_i |=> rec[POS_VSUP]); // R4
  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
    (!$past(wdt_ovf_i) && !$past(vsup_trip_i) && !$past(por_i) && !$past(wr_seen)
     && !wdt_ovf_i && !vsup_trip_i) |-> rec == $past(rec)); // R5
  AST_SRC_HOLDS_RST: assert property (@(posedge clk_i) disable iff (por_i)
    any_src |-> !sys_rst_no); // R9
  AST_RELEASE_LATE: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(sys_rst_no) |-> !$past(any_src)); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (por_i)
    !(sel_i && !we_i) |-> rdata_o == '0); // R10
endmodule

bind rcc_unit rcc_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_i       (por_i),
  .wdt_ovf_i   (wdt_ovf_i),
  .vsup_trip_i (vsup_trip_i),
  .sel_i       (sel_i),
  .we_i        (we_i),
  .rdata_o     (rdata_o),
  .sys_rst_no  (sys_rst_no),
  .rec         (rec)
);

// File: tb/rcc_unit_test.sv
module rcc_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       por_i = 1'b1;
  logic       wdt_ovf_i = 1'b0;
  logic       vsup_trip_i = 1'b0;
  logic       sel_i = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       sys_rst_no;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rcc_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_i(por_i), .wdt_ovf_i(wdt_ovf_i),
    .vsup_trip_i(vsup_trip_i), .sel_i(sel_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .sys_rst_no(sys_rst_no)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0; wdata_i = 8'h00;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b0;
    #1 d = rdata_o;
    sel_i = 1'b0;
  endtask

  // release all sources, then check two-edge release
  task automatic release_chk(input string req);
    @(negedge clk_i);
    rst_ni = 1'b1; por_i = 1'b0; wdt_ovf_i = 1'b0; vsup_trip_i = 1'b0;
    @(negedge clk_i);
    check({req, " one edge after release"}, {7'd0, sys_rst_no}, 8'h00);
    @(negedge clk_i);
    check({req, " two edges after release"}, {7'd0, sys_rst_no}, 8'h01);
  endtask

  task automatic t_power_on();
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    check("R9 reset held during power-on", {7'd0, sys_rst_no}, 8'h00);
    release_chk("R9");
    rd(d);
    check("R2 power-on flag", d & 8'h01, 8'h01);
    check("R1 reserved bits zero", d & 8'hDA, 8'h00);
    wr(8'h00);
    rd(d);
    check("R7 clear by 00h", d, 8'h00);
  endtask

  task automatic t_write_mask();
    logic [7:0] d;
    wr(8'hFF);
    rd(d);
    check("R1 R7 write FFh reads 25h", d, 8'h25);
    wr(8'h04);
    rd(d);
    check("R7 write 04h", d, 8'h04);
    wr(8'h00);
  endtask

  task automatic t_idle_rdata();
    wr(8'h25);
    @(negedge clk_i);
    #1 check("R10 no select", rdata_o, 8'h00);
    sel_i = 1'b1; we_i = 1'b1; wdata_i = 8'h25;
    #1 check("R10 write cycle", rdata_o, 8'h00);
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
    wr(8'h00);
  endtask

  task automatic t_pin_reset();
    logic [7:0] d;
    wr(8'h01);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R5 pin asserts reset", {7'd0, sys_rst_no}, 8'h00);
    repeat (2) @(negedge clk_i);
    release_chk("R5");
    rd(d);
    check("R5 R6 pin leaves record", d, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_accumulate();
    logic [7:0] d;
    @(negedge clk_i);
    wdt_ovf_i = 1'b1;
    repeat (2) @(negedge clk_i);
    release_chk("R9 watchdog");
    rd(d);
    check("R3 watchdog flag", d, 8'h04);
    @(negedge clk_i);
    vsup_trip_i = 1'b1;
    repeat (2) @(negedge clk_i);
    release_chk("R9 supervisor");
    rd(d);
    check("R4 R6 watchdog then supervisor", d, 8'h24);
    @(negedge clk_i);
    por_i = 1'b1;
    repeat (2) @(negedge clk_i);
    release_chk("R9 power-on");
    rd(d);
    check("R2 R6 all three", d, 8'h25);
    wr(8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk_i);
    wdt_ovf_i = 1'b1;
    sel_i = 1'b1; we_i = 1'b1; wdata_i = 8'h00;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
    release_chk("R9");
    rd(d);
    check("R8 set beats clear", d, 8'h04);
    wr(8'h00);
    rd(d);
    check("R7 clear after set", d, 8'h00);
  endtask

  task automatic t_async_assert();
    @(negedge clk_i);
    #3 vsup_trip_i = 1'b1;
    #1 check("R9 immediate assert", {7'd0, sys_rst_no}, 8'h00);
    repeat (2) @(negedge clk_i);
    release_chk("R9");
    wr(8'h00);
  endtask

  initial begin
    fork
      begin
        t_power_on();
        t_write_mask();
        t_idle_rdata();
        t_pin_reset();
        t_accumulate();
        t_set_wins();
        t_async_assert();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
          checks++; failures++;
          $display("FAIL watchdog expired actual=hung expected=done");
        end
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule